// File: doc/BRIEF.md
# Synchronizable Integer Clock Divider

This block divides its input clock by a programmable integer from 1 to 8. It produces two outputs: a divided clock level, and a one-cycle enable that marks the start of each divided period. An external alignment input can force the divider counter and its output phase back to the initial state. When several dividers receive the same alignment edge, they start their divided periods on the same input cycle.

A single control word selects the following:
- the divide ratio;
- whether alignment requests are honoured at all;
- whether every request is honoured (continuous mode) or only the first one after the word is written (one-shot mode).

The block also drives a stabilizer-enable output. This output is forced high for any ratio other than divide-by-1, whatever the user setting is. Each accepted alignment event gives a one-cycle acknowledge pulse.

Control word layout (`cfg_wdata_i`):
- bit 0: user stabilizer request
- bit 1: alignment enable
- bit 2: one-shot select
- bits [5:3]: ratio code, equal to N-1

Top module: `sync_clk_divider`

## Requirements
- R1: With ratio code c (N = c+1), `div_en_o` is high for exactly one cycle in every N cycles. That cycle is the one where the phase counter is at 0. For N=1 it is high on every cycle.
- R2: `div_clk_o` is high for the first floor(N/2) cycles of each period and low for the rest. For N=1 it stays high.
- R3: From the cycle after a write, `dcs_en_o` equals bit 0 OR (bits [5:3] != 0).
- R4: While bit 1 is clear, `sync_i` has no effect. No acknowledge is given and the divided outputs keep their period.
- R5: In continuous mode (bit 1 set, bit 2 clear), every rising edge of `sync_i` is accepted. Suppose `sync_i` is sampled high at edge k after being sampled low at edge k-1. Then from edge k+2 the phase is back at 0 (`div_en_o` high, `div_clk_o` high) and `sync_ack_o` is high for that one cycle.
- R6: In one-shot mode (bits 1 and 2 set), only the first rising edge after a control write is accepted. Later edges are ignored until the next write.
- R7: A control write re-arms one-shot acceptance. Reset also leaves the block armed.
- R8: Only a low-to-high transition of `sync_i` counts as an event. Holding it high gives one event.
- R9: A new ratio code takes effect at the next counter wrap or at the next accepted event, whichever comes first. Until then the old period continues unchanged.
- R10: After reset the control word is all zero. This means divide-by-1, alignment off, continuous mode and no user stabilizer request. The phase is 0 and `sync_ack_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 6 | Control word write data |
| sync_i | input | 1 | Alignment request, asynchronous |
| div_clk_o | output | 1 | Divided clock level |
| div_en_o | output | 1 | Period-start enable |
| dcs_en_o | output | 1 | Stabilizer enable |
| sync_ack_o | output | 1 | Accepted-alignment pulse |

## Verification
The assertions take for granted that `sync_i` never rises on two consecutive samples, since any rising edge needs a low sample before it. The acknowledge-spacing check relies on this. The one-shot check assumes the mode bits change only through a write, and a write also clears its record of acceptances. The stimulus drives `sync_i` as pulses or holds with low gaps between them, from a fixed seed. It spreads control writes thinly enough that events in one-shot and continuous mode are seen both with and without a write in between.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CODE_W = 3;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic [CODE_W-1:0] code;      // ratio minus one
    logic              one_shot;
    logic              sync_en;
    logic              dcs_user;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/cdiv_sync_in.sv
module cdiv_sync_in #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], sync_i};
  end

  // edge taken after the synchronizer, extra flop holds previous level
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/cdiv_arm.sv
module cdiv_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic sync_en_i,
  input  logic one_shot_i,
  input  logic rise_i,
  output logic accept_o,
  output logic ack_o
);
  logic armed_q;

  assign accept_o = rise_i & sync_en_i & (~one_shot_i | armed_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      ack_o   <= 1'b0;
    end else begin
      ack_o <= accept_o;
      if (we_i)          armed_q <= 1'b1;
      else if (accept_o) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cdiv_core.sv
module cdiv_core #(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              accept_i,
  output logic              div_clk_o,
  output logic              div_en_o
);
  logic [CODE_W-1:0] cnt_q, cur_q;
  logic [CODE_W:0]   n_full, half;
  logic              wrap;

  assign wrap   = (cnt_q == cur_q);
  assign n_full = {1'b0, cur_q} + 1'b1;
  assign half   = n_full >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cur_q <= '0;
    end else if (accept_i || wrap) begin
      cnt_q <= '0;
      cur_q <= code_i;   // ratio only swaps at a period boundary
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign div_en_o  = (cnt_q == '0);
  assign div_clk_o = (cur_q == '0) | ({1'b0, cnt_q} < half);
endmodule

// File: rtl/sync_clk_divider.sv
module sync_clk_divider
  import clkdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             sync_i,
  output logic             div_clk_o,
  output logic             div_en_o,
  output logic             dcs_en_o,
  output logic             sync_ack_o
);
  cfg_t cfg_q;
  logic rise, accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_t'(cfg_wdata_i);
  end

  assign dcs_en_o = cfg_q.dcs_user | (cfg_q.code != '0);

  cdiv_sync_in #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(sync_i),
    .rise_o(rise)
  );

  cdiv_arm u_arm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .sync_en_i (cfg_q.sync_en),
    .one_shot_i(cfg_q.one_shot),
    .rise_i    (rise),
    .accept_o  (accept),
    .ack_o     (sync_ack_o)
  );

  cdiv_core #(.CODE_W(CODE_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .code_i   (cfg_q.code),
    .accept_i (accept),
    .div_clk_o(div_clk_o),
    .div_en_o (div_en_o)
  );
endmodule

// File: rtl/sync_clk_divider_chk.sv
module sync_clk_divider_chk
  import clkdiv_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [CODE_W-1:0] wr_code_i,
  input logic              div_clk_o,
  input logic              div_en_o,
  input logic              dcs_en_o,
  input logic              sync_ack_o,
  input logic              accept,
  input cfg_t              cfg_q,
  input logic [CODE_W-1:0] cur_code
);
  logic seen_q;  // an event was accepted since the last write

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       seen_q <= 1'b0;
    else if (cfg_we_i) seen_q <= 1'b0;
    else if (accept)   seen_q <= 1'b1;
  end

  p_div1_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_code == '0) |-> (div_clk_o && div_en_o));

  p_dcs_forced_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && wr_code_i != '0) |=> dcs_en_o);

  p_sync_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q.sync_en |=> !sync_ack_o);

  p_ack_phase_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_ack_o |-> (div_en_o && div_clk_o));

  p_one_shot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && cfg_q.one_shot) |-> !accept);

  p_single_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_ack_o |=> !sync_ack_o);
endmodule

bind sync_clk_divider sync_clk_divider_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_we_i  (cfg_we_i),
  .wr_code_i (cfg_wdata_i[5:3]),
  .div_clk_o (div_clk_o),
  .div_en_o  (div_en_o),
  .dcs_en_o  (dcs_en_o),
  .sync_ack_o(sync_ack_o),
  .accept    (accept),
  .cfg_q     (cfg_q),
  .cur_code  (u_core.cur_q)
);

// File: tb/sync_clk_divider_tb_top.sv
module sync_clk_divider_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [5:0] cfg_wdata_i = '0;
  logic       sync_i = 1'b0;
  logic       div_clk_o, div_en_o, dcs_en_o, sync_ack_o;

  int checks = 0;
  int failures = 0;
  int acks = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  sync_clk_divider dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .sync_i(sync_i), .div_clk_o(div_clk_o), .div_en_o(div_en_o),
    .dcs_en_o(dcs_en_o), .sync_ack_o(sync_ack_o)
  );

  // reference state built from the requirements
  logic [5:0] m_cfg;
  logic [2:0] m_sh, m_cnt, m_cur;
  logic       m_armed, m_ack;

  function automatic logic exp_en(input logic [2:0] cnt);
    return cnt == 3'd0;
  endfunction
  function automatic logic exp_clk(input logic [2:0] cur, input logic [2:0] cnt);
    int n = int'(cur) + 1;
    return (n == 1) || (int'(cnt) < n / 2);
  endfunction
  function automatic logic exp_dcs(input logic [5:0] c);
    return c[0] | (c[5:3] != 3'd0);
  endfunction

  wire m_rise = m_sh[1] & ~m_sh[2];
  wire m_acc  = m_rise & m_cfg[1] & (~m_cfg[2] | m_armed);

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cfg <= '0; m_sh <= '0; m_cnt <= '0; m_cur <= '0; m_armed <= 1'b1; m_ack <= 1'b0;
    end else begin
      m_sh  <= {m_sh[1:0], sync_i};
      m_ack <= m_acc;
      if (cfg_we_i) m_armed <= 1'b1;
      else if (m_acc) m_armed <= 1'b0;
      if (m_acc || m_cnt == m_cur) begin
        m_cnt <= '0;
        m_cur <= m_cfg[5:3];
      end else begin
        m_cnt <= m_cnt + 3'd1;
      end
      if (cfg_we_i) m_cfg <= cfg_wdata_i;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare all outputs against the reference, then drive next inputs
  task automatic step(input logic we, input logic [5:0] wd, input logic s);
    @(negedge clk_i);
    chk(div_en_o == exp_en(m_cnt), "R1 div_en", int'(div_en_o), int'(exp_en(m_cnt)));
    chk(div_clk_o == exp_clk(m_cur, m_cnt), (m_cfg[5:3] != m_cur) ? "R9 div_clk" : "R2 div_clk",
        int'(div_clk_o), int'(exp_clk(m_cur, m_cnt)));
    chk(dcs_en_o == exp_dcs(m_cfg), "R3 dcs_en", int'(dcs_en_o), int'(exp_dcs(m_cfg)));
    chk(sync_ack_o == m_ack, !m_cfg[1] ? "R4 ack" : (m_cfg[2] ? "R6 ack" : "R5 ack"),
        int'(sync_ack_o), int'(m_ack));
    if (sync_ack_o) acks++;
    cfg_we_i = we; cfg_wdata_i = wd; sync_i = s;
  endtask

  task automatic idle(input int n, input logic s);
    for (int i = 0; i < n; i++) step(1'b0, '0, s);
  endtask

  task automatic wr(input logic [5:0] wd);
    step(1'b1, wd, 1'b0);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b0, '0, 1'b1);
      idle(5, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R10: reset state seen at the ports
    chk(div_clk_o && div_en_o, "R10 phase", int'({div_clk_o, div_en_o}), 3);
    chk(!dcs_en_o && !sync_ack_o, "R10 flags", int'({dcs_en_o, sync_ack_o}), 0);
    rst_ni = 1'b1;

    // R1/R2/R3: each ratio, alignment off
    for (int c = 0; c < 8; c++) begin
      wr({3'(c), 3'b000});
      idle(30, 1'b0);
    end
    wr({3'd0, 3'b001});  // user request only
    idle(4, 1'b0);
    chk(dcs_en_o, "R3 user bit", int'(dcs_en_o), 1);

    // R4: alignment disabled
    wr({3'd4, 3'b000});
    acks = 0;
    pulses(4);
    chk(acks == 0, "R4 ignored", acks, 0);

    // R5: continuous mode, every edge accepted
    wr({3'd5, 3'b010});
    acks = 0;
    pulses(5);
    chk(acks == 5, "R5 count", acks, 5);

    // R8: held high is one event
    acks = 0;
    idle(20, 1'b1);
    idle(4, 1'b0);
    chk(acks == 1, "R8 held", acks, 1);

    // R6: one-shot accepts only the first
    wr({3'd3, 3'b110});
    acks = 0;
    pulses(4);
    chk(acks == 1, "R6 one-shot", acks, 1);
    // R7: rewrite re-arms
    wr({3'd3, 3'b110});
    pulses(3);
    chk(acks == 2, "R7 rearm", acks, 2);

    // R9: ratio change mid-period
    wr({3'd7, 3'b000});
    idle(3, 1'b0);
    wr({3'd1, 3'b000});
    idle(20, 1'b0);

    // constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic we = ($urandom % 24) == 0;
      logic [5:0] wd = 6'($urandom);
      int hold = 1 + int'($urandom % 4);
      step(we, wd, 1'b1);
      for (int j = 1; j < hold; j++) step(1'b0, '0, 1'b1);
      idle(1 + int'($urandom % 10), 1'b0);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule